// File: doc/BRIEF.md
# Scalar-to-Vector Loop Issue Expander

This block sits between instruction decode and issue. It takes one decoded scalar register-register operation and, when one or more of its register operands are marked as vectors and a global vector length of two or more is set, replays that operation once per element. Element `i` of the loop adds `i` to every marked register number and leaves the other numbers unchanged. The opcode is never altered, so the execution units see only ordinary scalar operations. One micro-op leaves per cycle towards the issue FIFO under a valid/ready handshake.

The element index is architectural state. A downstream trap is signalled through `abort`. This freezes the index at the element that was on the output and returns the block to idle. Trap software reads the index and can later reload it through `restore`. The re-issued instruction then resumes from that element. Register 0 is the hard-wired zero register and is never offset. An element whose offset register number would pass 63 is not emitted. Instead the loop ends and an error flag is raised.

Top module: `vec_issue_expander`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1, `idx_o` is 0, `err` is 0, and the vector length is 0.
- R2: With vector length N ≥ 2 and at least one operand marked, an accepted instruction produces N micro-ops in order. Element i carries the unchanged opcode and, for each marked operand, the register number plus i. Marking bits are `in_vec[0]` for rd, `in_vec[1]` for rs1 and `in_vec[2]` for rs2.
- R3: An unmarked operand keeps the same register number in every element.
- R4: A marked operand whose register number is 0 stays 0 in every element.
- R5: With vector length 0 or 1, or with no operand marked, exactly one unmodified micro-op is produced, and it has `out_last` = 1.
- R6: While `out_valid` is 1 and `out_ready` is 0, the presented micro-op and `idx_o` hold steady.
- R7: `in_ready` is 0 from the cycle after acceptance until the cycle after the last element's handshake. It is then 1 again and `idx_o` is 0.
- R8: If any marked nonzero operand plus the element index exceeds 63, that element is not emitted. The block returns to idle with `idx_o` = 0, and `err` goes to 1 until the next instruction is accepted.
- R9: `abort` while busy drops `out_valid` in the next cycle, keeps `idx_o` at the index of the presented element, and returns `in_ready` to 1.
- R10: `restore` while idle loads `restore_idx` into `idx_o` and blocks acceptance for that cycle. The next vector instruction starts at that element.
- R11: With vector length 63 and base register 1, the elements cover registers 1 through 63 without error.
- R12: `out_last` is 1 on the final element of a loop and 0 on all earlier elements.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vl_we | input | 1 | Write strobe for the vector length |
| vl_wdata | input | 6 | New vector length (0..63) |
| in_valid | input | 1 | Decoded instruction valid |
| in_ready | output | 1 | Expander can accept an instruction |
| in_op | input | 8 | Opcode and function bits, passed through |
| in_rd | input | 6 | Destination register number |
| in_rs1 | input | 6 | First source register number |
| in_rs2 | input | 6 | Second source register number |
| in_vec | input | 3 | Vector marks: bit0 rd, bit1 rs1, bit2 rs2 |
| out_valid | output | 1 | Micro-op valid |
| out_ready | input | 1 | Issue FIFO can take a micro-op |
| out_op | output | 8 | Micro-op opcode |
| out_rd | output | 6 | Micro-op destination register |
| out_rs1 | output | 6 | Micro-op first source register |
| out_rs2 | output | 6 | Micro-op second source register |
| out_last | output | 1 | Final element of the loop |
| abort | input | 1 | Trap on the presented element |
| restore | input | 1 | Load a saved element index (idle only) |
| restore_idx | input | 6 | Saved element index to load |
| idx_o | output | 6 | Current element index |
| err | output | 1 | Register-range overflow flag |

## Verification
The first micro-op of an accepted instruction is visible in the cycle after the acceptance edge. Each further element appears one cycle after the handshake of the previous one. `in_ready` returns and `idx_o` clears one cycle after the last handshake. `err`, the frozen abort index and a restored index each become visible one cycle after the event that causes them. An overflowing element shows as a missing `out_valid` in its own cycle. The bench drives inputs on falling edges and samples on the next falling edge, so each check lands exactly one register stage after its cause. Overflow cases are checked twice: `out_valid` low in the element's own cycle, then `err` and `in_ready` one cycle later.

// File: rtl/vec_issue_expander.sv
module vec_issue_expander #(
  parameter int OP_W  = 8,
  parameter int REG_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vl_we,
  input  logic [REG_W-1:0] vl_wdata,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [OP_W-1:0]  in_op,
  input  logic [REG_W-1:0] in_rd,
  input  logic [REG_W-1:0] in_rs1,
  input  logic [REG_W-1:0] in_rs2,
  input  logic [2:0]       in_vec,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OP_W-1:0]  out_op,
  output logic [REG_W-1:0] out_rd,
  output logic [REG_W-1:0] out_rs1,
  output logic [REG_W-1:0] out_rs2,
  output logic             out_last,
  input  logic             abort,
  input  logic             restore,
  input  logic [REG_W-1:0] restore_idx,
  output logic [REG_W-1:0] idx_o,
  output logic             err
);

  logic             busy;
  logic [OP_W-1:0]  h_op;
  logic [REG_W-1:0] h_rd, h_rs1, h_rs2;
  logic [2:0]       h_vec;
  logic [REG_W-1:0] vl, idx;
  logic [REG_W:0]   s_rd, s_rs1, s_rs2;
  logic             active, ovf, fire;

  function automatic logic [REG_W:0] step(input logic [REG_W-1:0] r, input logic m,
                                          input logic act, input logic [REG_W-1:0] i);
    if (act && m && r != '0) return {1'b0, r} + {1'b0, i};
    return {1'b0, r};
  endfunction

  assign active = (vl > REG_W'(1)) && (|h_vec);
  assign s_rd   = step(h_rd,  h_vec[0], active, idx);
  assign s_rs1  = step(h_rs1, h_vec[1], active, idx);
  assign s_rs2  = step(h_rs2, h_vec[2], active, idx);
  assign ovf    = s_rd[REG_W] | s_rs1[REG_W] | s_rs2[REG_W];

  assign out_valid = busy && !ovf;
  assign out_op    = h_op;
  assign out_rd    = s_rd[REG_W-1:0];
  assign out_rs1   = s_rs1[REG_W-1:0];
  assign out_rs2   = s_rs2[REG_W-1:0];
  assign out_last  = !active || (idx >= vl - REG_W'(1));
  assign in_ready  = !busy && !restore;
  assign fire      = out_valid && out_ready && !abort;
  assign idx_o     = idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      vl    <= '0;
      idx   <= '0;
      err   <= 1'b0;
      h_op  <= '0;
      h_rd  <= '0;
      h_rs1 <= '0;
      h_rs2 <= '0;
      h_vec <= '0;
    end else begin
      if (vl_we) vl <= vl_wdata;
      if (!busy) begin
        if (restore) idx <= restore_idx;
        else if (in_valid) begin
          busy  <= 1'b1;
          err   <= 1'b0;
          h_op  <= in_op;
          h_rd  <= in_rd;
          h_rs1 <= in_rs1;
          h_rs2 <= in_rs2;
          h_vec <= in_vec;
        end
      end else if (abort) begin
        busy <= 1'b0;
      end else if (ovf) begin
        busy <= 1'b0;
        err  <= 1'b1;
        idx  <= '0;
      end else if (fire) begin
        if (out_last) begin
          busy <= 1'b0;
          idx  <= '0;
        end else begin
          idx <= idx + REG_W'(1);
        end
      end
    end
  end

  a_r6_hold_steady: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !abort && !vl_we |=>
      out_valid && $stable(out_rd) && $stable(out_rs1) && $stable(out_rs2)
      && $stable(out_op) && $stable(idx_o));

  a_r7_stall_decode: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  a_r12_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !abort && out_last |=> !out_valid && idx_o == '0);

  a_r9_abort_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && abort |=> !out_valid && $stable(idx_o));

  a_r8_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !out_valid);

  a_r4_zero_kept: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_rd == '0 |=> out_rd == '0);

endmodule

// File: tb/vec_issue_expander_test.sv
module vec_issue_expander_test;
  logic clk = 0, rst_n = 0;
  logic vl_we = 0; logic [5:0] vl_wdata = 0;
  logic in_valid = 0, in_ready;
  logic [7:0] in_op = 0; logic [5:0] in_rd = 0, in_rs1 = 0, in_rs2 = 0; logic [2:0] in_vec = 0;
  logic out_valid, out_ready = 1, out_last;
  logic [7:0] out_op; logic [5:0] out_rd, out_rs1, out_rs2;
  logic abort = 0, restore = 0; logic [5:0] restore_idx = 0, idx_o; logic err;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  vec_issue_expander uut (.clk, .rst_n, .vl_we, .vl_wdata, .in_valid, .in_ready, .in_op,
    .in_rd, .in_rs1, .in_rs2, .in_vec, .out_valid, .out_ready, .out_op, .out_rd, .out_rs1,
    .out_rs2, .out_last, .abort, .restore, .restore_idx, .idx_o, .err);

  // {vl, rd, rs1, rs2, vec, op}
  localparam logic [34:0] CASES [9] = '{
    {6'd4,  6'd5,  6'd10, 6'd20, 3'b111, 8'h33},
    {6'd4,  6'd8,  6'd2,  6'd3,  3'b001, 8'h13},
    {6'd1,  6'd5,  6'd6,  6'd7,  3'b111, 8'h21},
    {6'd0,  6'd9,  6'd10, 6'd11, 3'b111, 8'h22},
    {6'd3,  6'd12, 6'd13, 6'd14, 3'b000, 8'h23},
    {6'd5,  6'd0,  6'd7,  6'd9,  3'b111, 8'h40},
    {6'd3,  6'd62, 6'd1,  6'd2,  3'b001, 8'h41},
    {6'd63, 6'd1,  6'd1,  6'd0,  3'b011, 8'h42},
    {6'd2,  6'd30, 6'd40, 6'd50, 3'b110, 8'h43}
  };

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic issue(input int vl, input int op, input int rd, input int rs1, input int rs2, input int vec);
    @(negedge clk); vl_we = 1; vl_wdata = 6'(vl);
    @(negedge clk); vl_we = 0;
    chk(in_ready == 1, "R7", "in_ready before issue", in_ready, 1);
    in_valid = 1; in_op = 8'(op); in_rd = 6'(rd); in_rs1 = 6'(rs1); in_rs2 = 6'(rs2); in_vec = 3'(vec);
    @(negedge clk); in_valid = 0;
  endtask

  function automatic int offs(input int r, input bit m, input bit act, input int i);
    return (act && m && r != 0) ? r + i : r;
  endfunction

  // called on the negedge where the first micro-op should be visible
  task automatic expect_run(input int vl, input int op, input int rd, input int rs1, input int rs2,
                            input int vec, input int start);
    bit act = (vl >= 2) && (vec != 0);
    int n = act ? vl : 1;
    for (int i = (act ? start : 0); i < n; i++) begin
      int erd = offs(rd, vec[0], act, i), ers1 = offs(rs1, vec[1], act, i), ers2 = offs(rs2, vec[2], act, i);
      if (erd > 63 || ers1 > 63 || ers2 > 63) begin
        chk(out_valid == 0, "R8", "no emit on overflow", out_valid, 0);
        @(negedge clk);
        chk(err == 1, "R8", "err raised", err, 1);
        chk(in_ready == 1, "R8", "idle after overflow", in_ready, 1);
        chk(idx_o == 0, "R8", "index cleared", idx_o, 0);
        return;
      end
      if (i == (act ? start : 0)) chk(err == 0, "R8", "err cleared on accept", err, 0);
      chk(out_valid == 1, act ? "R2" : "R5", "out_valid", out_valid, 1);
      chk(in_ready == 0, "R7", "decode stalled", in_ready, 0);
      chk(out_op == op, "R2", "opcode", out_op, op);
      chk(out_rd == erd, vec[0] ? (rd == 0 ? "R4" : "R2") : "R3", "rd", out_rd, erd);
      chk(out_rs1 == ers1, vec[1] ? "R2" : "R3", "rs1", out_rs1, ers1);
      chk(out_rs2 == ers2, vec[2] ? "R2" : "R3", "rs2", out_rs2, ers2);
      chk(out_last == (i == n - 1), n == 1 ? "R5" : "R12", "out_last", out_last, i == n - 1);
      @(negedge clk);
    end
    chk(out_valid == 0, "R7", "done valid", out_valid, 0);
    chk(in_ready == 1, "R7", "ready after last", in_ready, 1);
    chk(idx_o == 0, "R7", "index back to 0", idx_o, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(out_valid == 0, "R1", "reset out_valid", out_valid, 0);
    chk(in_ready == 1, "R1", "reset in_ready", in_ready, 1);
    chk(idx_o == 0, "R1", "reset idx", idx_o, 0);
    chk(err == 0, "R1", "reset err", err, 0);
    // R1 + R5: reset vector length 0 passes a marked op unmodified
    in_valid = 1; in_op = 8'h77; in_rd = 6'd3; in_rs1 = 6'd4; in_rs2 = 6'd5; in_vec = 3'b111;
    @(negedge clk); in_valid = 0;
    expect_run(0, 8'h77, 3, 4, 5, 7, 0);

    // table walk: R2 R3 R4 R5 R8 R11 R12
    for (int k = 0; k < 9; k++) begin
      logic [34:0] e = CASES[k];
      issue(e[34:29], e[7:0], e[28:23], e[22:17], e[16:11], e[10:8]);
      expect_run(e[34:29], e[7:0], e[28:23], e[22:17], e[16:11], e[10:8], 0);
    end

    // R6: backpressure holds the micro-op
    out_ready = 0;
    issue(3, 8'h50, 4, 5, 6, 7);
    repeat (3) begin
      chk(out_valid == 1 && out_rd == 4 && out_rs1 == 5 && out_rs2 == 6, "R6", "held element 0", out_rd, 4);
      chk(idx_o == 0, "R6", "index held", idx_o, 0);
      @(negedge clk);
    end
    out_ready = 1;
    expect_run(3, 8'h50, 4, 5, 6, 7, 0);

    // R9 + R10: abort at element 2, restore to 3, resume
    issue(6, 8'h60, 10, 20, 30, 1);
    @(negedge clk); @(negedge clk);
    chk(out_rd == 12, "R9", "at element 2", out_rd, 12);
    out_ready = 0; abort = 1;
    @(negedge clk); abort = 0;
    chk(out_valid == 0, "R9", "valid dropped", out_valid, 0);
    chk(idx_o == 2, "R9", "index frozen", idx_o, 2);
    chk(in_ready == 1, "R9", "idle after abort", in_ready, 1);
    restore = 1; restore_idx = 6'd3;
    #1 chk(in_ready == 0, "R10", "ready low during restore", in_ready, 0);
    @(negedge clk); restore = 0;
    chk(idx_o == 3, "R10", "index restored", idx_o, 3);
    out_ready = 1;
    issue(6, 8'h60, 10, 20, 30, 1);
    expect_run(6, 8'h60, 10, 20, 30, 1, 3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule